// File: doc/BRIEF.md
# Configurable GPIO Port with Edge-Triggered Interrupts

This block controls a port of eight general-purpose pins, each programmed through its own bits of a small register file on a simple write-strobe register bus. For every pin, software sets the drive direction, the driven level, the use of the pad resistor, and which of four sources drives the pin. A pin can be driven by its own output bit or by one of three peripheral output signals. Pad inputs pass through a two-stage synchronizer. The synchronized value is readable, is handed to peripherals, and feeds an edge detector.

The edge detector is present only when the build parameter asks for it. When present, each pin can set a sticky flag on a rising or a falling edge, selectable per pin. The enabled flags are OR-ed into a single interrupt request. The output register has a second role. When a pin is an input and its resistor is enabled, the pin's output bit selects the pull direction.

Top module: `gpio_edge_port`

## Requirements
- R1: After synchronous reset, every register reads 0 and `pin_oe`, `pull_en`, `pull_up` and `irq` are all 0.
- R2: The output (address 1), direction (2), resistor-enable (3), primary select (4), secondary select (5), interrupt-enable (6) and edge-select (7) registers read back the last value written, one cycle after the write.
- R3: `pin_oe[i]` equals direction bit i (1 = drive, 0 = input).
- R4: The two-bit code {secondary[i], primary[i]} selects `pin_out[i]`: 00 the output register bit, 01 `alt1_out[i]`, 10 `alt2_out[i]`, 11 `alt3_out[i]`.
- R5: `pull_en[i]` is resistor-enable[i] AND NOT direction[i]. `pull_up[i]` is 1 only when `pull_en[i]` is 1 and output bit i is 1; otherwise the pull is downward.
- R6: A pad level becomes visible at read address 0 and on `mod_in` two clock edges after it is applied, and not after one.
- R7: With edge-select bit 0, a 0→1 change of the synchronized input sets flag i. With edge-select bit 1, a 1→0 change sets it. The opposite edge leaves the flag unchanged. The flag register is at address 8.
- R8: Flags are sticky. Writing 0 to a flag bit clears it, and writing 1 sets it. An edge arriving in the same cycle as a clearing write wins.
- R9: `irq` is 1 exactly when some flag bit and the matching interrupt-enable bit are both 1.
- R10: Writing the edge-select register while the inputs are steady sets no flag.
- R11: When built without interrupt support, the interrupt-enable, edge-select and flag registers read 0 whatever is written, and `irq` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pad_in | input | 8 | Pad input levels, asynchronous |
| alt1_out | input | 8 | Peripheral output for select code 01 |
| alt2_out | input | 8 | Peripheral output for select code 10 |
| alt3_out | input | 8 | Peripheral output for select code 11 |
| mod_in | output | 8 | Synchronized pad levels to peripherals |
| pin_oe | output | 8 | Per-pin output enable |
| pin_out | output | 8 | Per-pin driven value |
| pull_en | output | 8 | Per-pin resistor enable |
| pull_up | output | 8 | Per-pin pull direction, 1 = up |
| irq | output | 1 | Combined interrupt request |

## Verification
Several behaviours are checked on every cycle. These are: the reset state of the outputs; a direction write appearing on `pin_oe`; an output write reaching `pin_out` on pins in plain mode; a pull-up never shown without a pull enable; flags never clearing except through a flag write; and flags never changing while the synchronized input is steady and no flag write occurs. Other behaviours need the bench's scenarios. These are: the mapping of all four select codes, the exact two-edge synchronizer latency, which edge polarity sets which flag, the OR-reduction into `irq`, and the build without interrupts.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int PORT_W = 8;
    localparam int ADDR_W = 4;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_IN  = 4'd0,
        REG_OUT = 4'd1,
        REG_DIR = 4'd2,
        REG_REN = 4'd3,
        REG_FSA = 4'd4,
        REG_FSB = 4'd5,
        REG_IEN = 4'd6,
        REG_IES = 4'd7,
        REG_IFG = 4'd8
    } reg_addr_e;

    typedef enum logic [1:0] {
        FN_GPIO = 2'b00,
        FN_ALT1 = 2'b01,
        FN_ALT2 = 2'b10,
        FN_ALT3 = 2'b11
    } pin_fn_e;

    function automatic logic pick_fn(input pin_fn_e fn, input logic gp,
                                     input logic a1, input logic a2, input logic a3);
        case (fn)
            FN_ALT1: return a1;
            FN_ALT2: return a2;
            FN_ALT3: return a3;
            default: return gp;
        endcase
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = gpio_pkg::PORT_W,
    parameter int STAGES = gpio_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_pkg::*;
#(
    parameter int W       = PORT_W,
    parameter bit HAS_IRQ = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_sync,
    input  logic [W-1:0]      ifg_q,
    output logic [W-1:0]      out_q,
    output logic [W-1:0]      dir_q,
    output logic [W-1:0]      ren_q,
    output logic [W-1:0]      fsa_q,
    output logic [W-1:0]      fsb_q,
    output logic [W-1:0]      ien_q,
    output logic [W-1:0]      ies_q,
    output logic              ifg_wr
);
    localparam logic [W-1:0] IRQ_MASK = {W{HAS_IRQ}};

    reg_addr_e addr;
    assign addr   = reg_addr_e'(bus_addr);
    assign ifg_wr = bus_wr && (addr == REG_IFG);

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            dir_q <= '0;
            ren_q <= '0;
            fsa_q <= '0;
            fsb_q <= '0;
            ien_q <= '0;
            ies_q <= '0;
        end else if (bus_wr) begin
            case (addr)
                REG_OUT: out_q <= bus_wdata;
                REG_DIR: dir_q <= bus_wdata;
                REG_REN: ren_q <= bus_wdata;
                REG_FSA: fsa_q <= bus_wdata;
                REG_FSB: fsb_q <= bus_wdata;
                REG_IEN: ien_q <= bus_wdata & IRQ_MASK;
                REG_IES: ies_q <= bus_wdata & IRQ_MASK;
                default: ;
            endcase
        end
    end

    always_comb begin
        case (addr)
            REG_IN:  bus_rdata = pin_sync;
            REG_OUT: bus_rdata = out_q;
            REG_DIR: bus_rdata = dir_q;
            REG_REN: bus_rdata = ren_q;
            REG_FSA: bus_rdata = fsa_q;
            REG_FSB: bus_rdata = fsb_q;
            REG_IEN: bus_rdata = ien_q;
            REG_IES: bus_rdata = ies_q;
            REG_IFG: bus_rdata = ifg_q;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_outmux.sv
module gpio_outmux
    import gpio_pkg::*;
#(
    parameter int W = PORT_W
) (
    input  logic [W-1:0] out_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] ren_q,
    input  logic [W-1:0] fsa_q,
    input  logic [W-1:0] fsb_q,
    input  logic [W-1:0] alt1,
    input  logic [W-1:0] alt2,
    input  logic [W-1:0] alt3,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pull_en,
    output logic [W-1:0] pull_up
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        pin_fn_e fn_sel;
        assign fn_sel     = pin_fn_e'({fsb_q[i], fsa_q[i]});
        assign pin_oe[i]  = dir_q[i];
        assign pin_out[i] = pick_fn(fn_sel, out_q[i], alt1[i], alt2[i], alt3[i]);
        assign pull_en[i] = ren_q[i] & ~dir_q[i];
        assign pull_up[i] = pull_en[i] & out_q[i];
    end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
    parameter int W       = gpio_pkg::PORT_W,
    parameter bit HAS_IRQ = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] pin_sync,
    input  logic [W-1:0] ien_q,
    input  logic [W-1:0] ies_q,
    input  logic         ifg_wr,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] ifg_q,
    output logic         irq
);
    if (HAS_IRQ) begin : g_irq
        logic [W-1:0] prev_q;
        logic [W-1:0] rise;
        logic [W-1:0] fall;
        logic [W-1:0] hit;
        logic [W-1:0] flag_q;

        assign rise = pin_sync & ~prev_q;
        assign fall = ~pin_sync & prev_q;
        assign hit  = (ies_q & fall) | (~ies_q & rise);

        always_ff @(posedge clk) begin
            if (rst) begin
                prev_q <= '0;
                flag_q <= '0;
            end else begin
                prev_q <= pin_sync;
                flag_q <= (ifg_wr ? wdata : flag_q) | hit;
            end
        end

        assign ifg_q = flag_q;
        assign irq   = |(flag_q & ien_q);
    end else begin : g_noirq
        assign ifg_q = '0;
        assign irq   = 1'b0;
    end
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
    import gpio_pkg::*;
#(
    parameter int W       = PORT_W,
    parameter bit HAS_IRQ = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pad_in,
    input  logic [W-1:0]      alt1_out,
    input  logic [W-1:0]      alt2_out,
    input  logic [W-1:0]      alt3_out,
    output logic [W-1:0]      mod_in,
    output logic [W-1:0]      pin_oe,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pull_en,
    output logic [W-1:0]      pull_up,
    output logic              irq
);
    logic [W-1:0] pin_sync;
    logic [W-1:0] out_q, dir_q, ren_q, fsa_q, fsb_q, ien_q, ies_q, ifg_q;
    logic         ifg_wr;

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
    );

    gpio_regs #(.W(W), .HAS_IRQ(HAS_IRQ)) u_regs (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_sync(pin_sync),
        .ifg_q(ifg_q), .out_q(out_q), .dir_q(dir_q), .ren_q(ren_q),
        .fsa_q(fsa_q), .fsb_q(fsb_q), .ien_q(ien_q), .ies_q(ies_q),
        .ifg_wr(ifg_wr)
    );

    gpio_outmux #(.W(W)) u_mux (
        .out_q(out_q), .dir_q(dir_q), .ren_q(ren_q), .fsa_q(fsa_q),
        .fsb_q(fsb_q), .alt1(alt1_out), .alt2(alt2_out), .alt3(alt3_out),
        .pin_oe(pin_oe), .pin_out(pin_out), .pull_en(pull_en), .pull_up(pull_up)
    );

    gpio_edge_irq #(.W(W), .HAS_IRQ(HAS_IRQ)) u_irq (
        .clk(clk), .rst(rst), .pin_sync(pin_sync), .ien_q(ien_q),
        .ies_q(ies_q), .ifg_wr(ifg_wr), .wdata(bus_wdata),
        .ifg_q(ifg_q), .irq(irq)
    );

    assign mod_in = pin_sync;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk
    import gpio_pkg::*;
#(
    parameter int W = PORT_W
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [W-1:0]      bus_wdata,
    input logic [W-1:0]      pin_oe,
    input logic [W-1:0]      pin_out,
    input logic [W-1:0]      pull_en,
    input logic [W-1:0]      pull_up,
    input logic              irq,
    input logic [W-1:0]      fsa,
    input logic [W-1:0]      fsb,
    input logic [W-1:0]      sync,
    input logic [W-1:0]      ifg
);
    logic flag_wr;
    assign flag_wr = bus_wr && (bus_addr == REG_IFG);

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pin_oe == '0 && pull_en == '0 && pull_up == '0 && !irq));

    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_DIR) |=> (pin_oe == $past(bus_wdata)));

    // R4
    gpio_out_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_OUT && (fsa | fsb) == '0)
        |=> (pin_out == $past(bus_wdata)));

    // R5
    pull_up_gated_chk: assert property (@(posedge clk) disable iff (rst)
        (pull_up & ~pull_en) == '0);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_wr |=> ((ifg & $past(ifg)) == $past(ifg)));

    // R10
    flag_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!flag_wr && $stable(sync)) |=> $stable(ifg));
endmodule

bind gpio_edge_port gpio_port_chk #(.W(W)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .pin_oe(pin_oe), .pin_out(pin_out),
    .pull_en(pull_en), .pull_up(pull_up), .irq(irq), .fsa(fsa_q),
    .fsb(fsb_q), .sync(pin_sync), .ifg(ifg_q)
);

// File: tb/tb_gpio_edge_port.sv
module tb_gpio_edge_port;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0;
    logic [3:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] pad_in = '0;
    logic [7:0] alt1 = '0, alt2 = '0, alt3 = '0;
    logic [7:0] rdata, rdata_n, mod_in, mod_in_n;
    logic [7:0] pin_oe, pin_out, pull_en, pull_up;
    logic [7:0] oe_n, out_n, pe_n, pu_n;
    logic       irq, irq_n;
    int         n_chk = 0, n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    gpio_edge_port #(.W(8), .HAS_IRQ(1'b1)) dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata), .pad_in(pad_in),
        .alt1_out(alt1), .alt2_out(alt2), .alt3_out(alt3), .mod_in(mod_in),
        .pin_oe(pin_oe), .pin_out(pin_out), .pull_en(pull_en),
        .pull_up(pull_up), .irq(irq)
    );

    gpio_edge_port #(.W(8), .HAS_IRQ(1'b0)) dut_noirq (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata_n), .pad_in(pad_in),
        .alt1_out(alt1), .alt2_out(alt2), .alt3_out(alt3), .mod_in(mod_in_n),
        .pin_oe(oe_n), .pin_out(out_n), .pull_en(pe_n),
        .pull_up(pu_n), .irq(irq_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d, output logic [7:0] dn);
        bus_wr = 1'b0; bus_addr = a;
        #1;
        d = rdata; dn = rdata_n;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d, dn;
        for (int a = 0; a < 9; a++) begin
            rd(a[3:0], d, dn);
            check("R1 reg read", d, 8'h00);
        end
        check("R1 pin_oe", pin_oe, 8'h00);
        check("R1 pull_en", pull_en, 8'h00);
        check("R1 pull_up", pull_up, 8'h00);
        check("R1 irq", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_readback();
        logic [7:0] d, dn, v;
        for (int a = 1; a < 8; a++) begin
            v = 8'h11 * a[7:0] ^ 8'h96;
            wr(a[3:0], v);
            rd(a[3:0], d, dn);
            check("R2 readback", d, v);
            wr(a[3:0], 8'h00);
        end
    endtask

    task automatic t_direction();
        wr(4'd2, 8'hA5);
        check("R3 pin_oe", pin_oe, 8'hA5);
        wr(4'd2, 8'h00);
        check("R3 pin_oe cleared", pin_oe, 8'h00);
    endtask

    task automatic t_mux();
        logic [7:0] exp;
        alt1 = 8'h33; alt2 = 8'h55; alt3 = 8'hCC;
        wr(4'd1, 8'h0F);
        wr(4'd4, 8'hCC);
        wr(4'd5, 8'hF0);
        for (int i = 0; i < 8; i++) begin
            case ({8'hF0 >> i & 8'h01, 8'hCC >> i & 8'h01})
                16'h0000: exp[i] = 8'h0F >> i & 1;
                16'h0001: exp[i] = alt1[i];
                16'h0100: exp[i] = alt2[i];
                default:  exp[i] = alt3[i];
            endcase
        end
        check("R4 mixed codes", pin_out, exp);
        alt1 = 8'hC3; alt2 = 8'h3C; alt3 = 8'h0F;
        #1;
        exp = (8'h0F & 8'h03) | (alt1 & 8'h0C) | (alt2 & 8'h30) | (alt3 & 8'hC0);
        check("R4 alt follow", pin_out, exp);
        wr(4'd4, 8'h00);
        wr(4'd5, 8'h00);
        check("R4 plain", pin_out, 8'h0F);
    endtask

    task automatic t_pull();
        wr(4'd2, 8'h0F);
        wr(4'd3, 8'hFF);
        wr(4'd1, 8'h3C);
        check("R5 pull_en", pull_en, 8'hF0);
        check("R5 pull_up", pull_up, 8'h30);
        wr(4'd3, 8'h00);
        wr(4'd2, 8'h00);
        wr(4'd1, 8'h00);
        check("R5 pull off", pull_en, 8'h00);
    endtask

    task automatic t_sync();
        logic [7:0] d, dn;
        @(negedge clk);
        pad_in = 8'h5A;
        @(negedge clk);
        rd(4'd0, d, dn);
        check("R6 one edge", d, 8'h00);
        @(negedge clk);
        rd(4'd0, d, dn);
        check("R6 two edges", d, 8'h5A);
        check("R6 mod_in", mod_in, 8'h5A);
    endtask

    task automatic t_edges();
        logic [7:0] d, dn, old, nw, exp;
        idle(2);
        wr(4'd8, 8'h00);
        wr(4'd7, 8'hF0);
        old = pad_in; nw = 8'hA5;
        @(negedge clk);
        pad_in = nw;
        idle(2);
        rd(4'd8, d, dn);
        check("R7 not yet", d, 8'h00);
        idle(1);
        exp = (8'hF0 & old & ~nw) | (8'h0F & nw & ~old);
        rd(4'd8, d, dn);
        check("R7 polarity", d, exp);
        check("R9 no enable", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_irq();
        wr(4'd6, 8'h04);
        check("R9 enabled flag", {7'b0, irq}, 8'h01);
        wr(4'd6, 8'h08);
        check("R9 enabled empty", {7'b0, irq}, 8'h00);
        wr(4'd6, 8'h00);
    endtask

    task automatic t_sticky();
        logic [7:0] d, dn;
        idle(3);
        rd(4'd8, d, dn);
        check("R8 hold", d, 8'h55);
        wr(4'd8, 8'h50);
        rd(4'd8, d, dn);
        check("R8 clear", d, 8'h50);
        wr(4'd8, 8'h81);
        rd(4'd8, d, dn);
        check("R8 set", d, 8'h81);
        wr(4'd8, 8'h00);
    endtask

    task automatic t_ies_toggle();
        logic [7:0] d, dn;
        wr(4'd7, 8'hFF);
        wr(4'd7, 8'h00);
        idle(2);
        rd(4'd8, d, dn);
        check("R10 no flag", d, 8'h00);
    endtask

    task automatic t_noirq();
        logic [7:0] d, dn;
        wr(4'd6, 8'hFF);
        rd(4'd6, d, dn);
        check("R11 ien", dn, 8'h00);
        wr(4'd7, 8'hFF);
        rd(4'd7, d, dn);
        check("R11 ies", dn, 8'h00);
        wr(4'd8, 8'hFF);
        rd(4'd8, d, dn);
        check("R11 ifg", dn, 8'h00);
        @(negedge clk);
        pad_in = 8'h00;
        idle(4);
        rd(4'd8, d, dn);
        check("R11 ifg after edges", dn, 8'h00);
        check("R11 irq", {7'b0, irq_n}, 8'h00);
        check("R9 main irq", {7'b0, irq}, 8'h01);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_readback();
        t_direction();
        t_mux();
        t_pull();
        t_sync();
        t_edges();
        t_irq();
        t_sticky();
        t_ies_toggle();
        t_noirq();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule